// File: doc/BRIEF.md
# Year Rollover Watcher with Power-Gated Management Interrupt

This block watches every update of a real-time clock's two-digit BCD year byte (the byte at clock index 09h) and notices when the year passes from 99 to 00. When that happens it sets a sticky century flag. That flag can only be cleared by software writing a one to it.

The block also reports the rollover as a system-management interrupt request, but only when the platform is in its working power state at that moment. When the platform is asleep the flag is still set, and no interrupt is raised. Firmware finds the flag on resume and fixes the stored century value.

The block keeps its own copy of the last year value it saw. It compares each new update strobe against that copy, so repeated writes of 00 do not raise the flag a second time. A one-hot flag may stop the interrupt in any state other than the working state.

Top module: `century_watch`

## Requirements
- R1: After reset the century flag `cent_flag` reads 0 and `smi_pulse` is 0, and the stored previous year is 8'h00. A first update of 8'h00 therefore does not trigger.
- R2: A rollover is detected only on a cycle with `yr_wr` high where the stored previous year is 8'h99 and `yr_val` is 8'h00. On the next clock edge `cent_flag` becomes 1.
- R3: Other updates never set `cent_flag` or pulse `smi_pulse`. This covers 8'h99 to any non-zero value, 8'h98 to 8'h00, and 8'h00 to 8'h00.
- R4: The stored previous year updates only on cycles with `yr_wr` high. Changes of `yr_val` while `yr_wr` is low have no effect.
- R5: On detection with `pwr_state` equal to 3'd0 (working state), `smi_pulse` is 1 for exactly the one cycle after the detecting edge, together with the flag being set.
- R6: On detection with `pwr_state` in 3'd1 through 3'd5 (sleep states), `cent_flag` is still set but `smi_pulse` stays 0.
- R7: `cent_flag` holds until a cycle with `clr_w1c` high. The flag then reads 0 after that edge. `clr_w1c` low has no effect.
- R8: If a detection and `clr_w1c` fall in the same cycle, the detection wins and `cent_flag` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| yr_wr | input | 1 | Year byte update strobe |
| yr_val | input | 8 | New BCD year value |
| pwr_state | input | 3 | Power state code, 0 = working, 1..5 = sleep |
| clr_w1c | input | 1 | Write-one-to-clear for the century flag |
| cent_flag | output | 1 | Sticky century rollover flag |
| smi_pulse | output | 1 | One-cycle management interrupt request |

## Verification
Setting the flag on detection and clearing it by software can fall in the same cycle. The bench provokes this by loading 99, then presenting the 00 update together with a clear strobe. It judges the result by reading `cent_flag` as 1 after that edge. It then checks that a lone clear afterwards does drop the flag. A detection in the working state also coincides with the interrupt pulse, and the bench checks that the pulse lasts exactly one cycle.

// File: rtl/century_watch.sv
module century_watch #(
  parameter int YW = 8,
  parameter int PW = 3,
  parameter logic [YW-1:0] LAST_YR = 8'h99,
  parameter logic [YW-1:0] FIRST_YR = 8'h00,
  parameter logic [PW-1:0] WORK_ST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          yr_wr,
  input  logic [YW-1:0] yr_val,
  input  logic [PW-1:0] pwr_state,
  input  logic          clr_w1c,
  output logic          cent_flag,
  output logic          smi_pulse
);

  logic [YW-1:0] prev_yr;
  logic          hit;

  assign hit = yr_wr && (prev_yr == LAST_YR) && (yr_val == FIRST_YR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_yr   <= FIRST_YR;
      cent_flag <= 1'b0;
      smi_pulse <= 1'b0;
    end else begin
      if (yr_wr) prev_yr <= yr_val;
      if (hit) cent_flag <= 1'b1;
      else if (clr_w1c) cent_flag <= 1'b0;
      smi_pulse <= hit && (pwr_state == WORK_ST);
    end
  end

  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    smi_pulse |=> !smi_pulse);
  assert_pulse_with_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    smi_pulse |-> cent_flag);
  assert_set_on_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> cent_flag);
  assert_sleep_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && pwr_state != WORK_ST) |=> !smi_pulse);
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cent_flag && !clr_w1c) |=> cent_flag);
  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cent_flag && !hit) |=> !cent_flag);

endmodule

// File: tb/tb_century_watch.sv
module tb_century_watch;
  logic clk = 0, rst_n = 0, yr_wr = 0, clr_w1c = 0;
  logic [7:0] yr_val = 0;
  logic [2:0] pwr_state = 0;
  logic cent_flag, smi_pulse;
  int nchk = 0, nbad = 0;

  always #2 clk = ~clk;

  century_watch dut (.clk(clk), .rst_n(rst_n), .yr_wr(yr_wr), .yr_val(yr_val),
    .pwr_state(pwr_state), .clr_w1c(clr_w1c), .cent_flag(cent_flag), .smi_pulse(smi_pulse));

  task automatic chk(string req, logic act, logic exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // drive on negedge, apply one edge, sample at following negedge
  task automatic step(logic wr, logic [7:0] v, logic clr);
    yr_wr = wr; yr_val = v; clr_w1c = clr;
    @(negedge clk);
    yr_wr = 0; clr_w1c = 0;
  endtask

  task automatic clear_all();
    step(0, 8'h00, 1);
    step(1, 8'h50, 0);
  endtask

  task automatic t_reset();
    chk("R1 flag", cent_flag, 0);
    chk("R1 smi", smi_pulse, 0);
    step(1, 8'h00, 0);
    chk("R1 first 00", cent_flag, 0);
  endtask

  task automatic t_work_roll();
    pwr_state = 0;
    step(1, 8'h99, 0);
    chk("R3 load 99", cent_flag, 0);
    step(1, 8'h00, 0);
    chk("R2 flag set", cent_flag, 1);
    chk("R5 smi", smi_pulse, 1);
    step(0, 8'h00, 0);
    chk("R5 one cycle", smi_pulse, 0);
    chk("R7 sticky", cent_flag, 1);
    step(1, 8'h00, 0);
    chk("R3 00 to 00 no smi", smi_pulse, 0);
    step(0, 8'h00, 1);
    chk("R7 cleared", cent_flag, 0);
    step(1, 8'h00, 0);
    chk("R3 no retrigger", cent_flag, 0);
  endtask

  task automatic t_non_triggers();
    step(1, 8'h99, 0);
    step(1, 8'h01, 0);
    chk("R3 99->01", cent_flag, 0);
    step(1, 8'h98, 0);
    step(1, 8'h00, 0);
    chk("R3 98->00", cent_flag, 0);
    step(1, 8'h99, 0);
    step(0, 8'h10, 0);
    yr_val = 8'h00; @(negedge clk);
    chk("R4 no strobe", cent_flag, 0);
    step(1, 8'h00, 0);
    chk("R4 prev kept 99", cent_flag, 1);
    clear_all();
  endtask

  task automatic t_sleep();
    for (int s = 1; s <= 5; s++) begin
      pwr_state = 3'(s);
      step(1, 8'h99, 0);
      step(1, 8'h00, 0);
      chk("R6 flag in sleep", cent_flag, 1);
      chk("R6 no smi", smi_pulse, 0);
      clear_all();
    end
    pwr_state = 0;
  endtask

  task automatic t_collide();
    step(1, 8'h99, 0);
    step(1, 8'h00, 1);
    chk("R8 detect wins", cent_flag, 1);
    chk("R8 smi", smi_pulse, 1);
    step(0, 8'h00, 0);
    chk("R7 no clr keeps", cent_flag, 1);
    step(0, 8'h00, 1);
    chk("R7 clear after", cent_flag, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    t_reset();
    t_work_roll();
    t_non_triggers();
    t_sleep();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule